// File: doc/BRIEF.md
# Gated Oscillator Frequency Meter

This block measures how fast an on-die oscillator runs. The oscillator sits outside the block and arrives here as an asynchronous clock. The block drives the oscillator's run gate from a register. The gate is high only while a measurement is in progress, so the oscillator stays stopped at all other times.

On a start request the block opens the gate and waits a programmable settle delay. It then counts rising edges of a divided copy of the oscillator for a programmable number of reference-clock cycles, closes the gate and pulses done. A binary divider in the oscillator domain provides power-of-two taps. The caller picks one tap so that the divided signal is slow enough for the reference domain to sample. The reported result is the edge count shifted left by the chosen ratio, so it is expressed in undivided oscillator cycles per window.

Top module: `osc_freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, `osc_en`, `busy`, `done`, `overflow` and `result` are all zero.
- R2: A `start` sampled high while idle is accepted. `busy` and `osc_en` are high from the next cycle on, and `osc_en` is never high while `busy` is low.
- R3: Counting from the clock edge that accepts `start`, `done` is high for exactly one cycle starting S+max(W,1)+1 edges later, where S is `settle_len` and W is `window_len`. `osc_en` falls on the same edge that raises `done`, and `busy` is low from the cycle after `done`.
- R4: `div_sel` = n (unsigned, 0 to 7) selects the tap running at the oscillator frequency divided by 2^n. n = 0 is the undivided oscillator, and a ratio of 64 (n = 6) is supported.
- R5: Rising edges of the selected tap are taken through a two-flop synchronizer and counted only during the W count cycles. The count matches the true number of tap edges in the window to within one edge.
- R6: After `done`, `result` equals the edge count shifted left by n, so its low n bits are zero. It holds that value until the next start is accepted.
- R7: The edge counter saturates at 2^CNT_W-1 and sets `overflow`, which stays high until the next start is accepted. A saturated run reports (2^CNT_W-1) shifted left by n.
- R8: `div_sel` is sampled only when a start is accepted. Changes of `div_sel` and further `start` pulses while busy have no effect on timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that sets the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator output, asynchronous to clk_ref |
| start | input | 1 | Request a measurement |
| div_sel | input | 3 | Power-of-two divide exponent n |
| settle_len | input | 8 | Reference cycles to wait after opening the gate |
| window_len | input | 16 | Count window in reference cycles |
| osc_en | output | 1 | Registered run gate for the oscillator |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 19 | Edge count scaled back to undivided cycles |
| overflow | output | 1 | Edge counter saturated during the last run |

## Verification
The oscillator model's period and the divide exponent are varied together. Slow undivided, mid-ratio, ratio-64 and ratio-128 runs each give a distinct expected count, so a wrong tap or a wrong shift falls outside the one-edge tolerance. A zero-length window and several settle lengths separate the settle and window timing in the done latency. A long window with a fast tap drives the counter into saturation, and a later normal run shows that the flag clears. A run that changes the divide select and pulses start mid-measurement shows that the sampled configuration holds.

// File: rtl/ofm_pkg.sv
package ofm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_COUNT  = 2'd2,
    ST_DONE   = 2'd3
  } ofm_state_e;
endpackage

// File: rtl/ofm_rst_sync.sv
module ofm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ofm_divider.sv
module ofm_divider #(
  parameter int STAGES = 7,
  localparam int SEL_W = $clog2(STAGES + 1)
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_out
);
  logic [STAGES-1:0] div_q;
  logic [STAGES:0]   taps;

  // binary counter: bit k toggles at osc/2^(k+1)
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign taps[0] = osc_clk;
  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    assign taps[k+1] = div_q[k];
  end

  assign tap_out = taps[sel];
endmodule

// File: rtl/ofm_edge_sync.sv
module ofm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/ofm_ctrl.sv
module ofm_ctrl
  import ofm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int WIN_W  = 16,
  parameter int SET_W  = 8,
  parameter int STAGES = 7,
  localparam int SEL_W = $clog2(STAGES + 1),
  localparam int TMR_W = (WIN_W > SET_W) ? WIN_W : SET_W,
  localparam int RES_W = CNT_W + STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [SET_W-1:0] settle_len,
  input  logic [WIN_W-1:0] window_len,
  input  logic             edge_pulse,
  output logic             osc_en,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [SEL_W-1:0] sel_q,
  output logic [RES_W-1:0] result
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ofm_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_d;
  logic             en_q, en_d, done_q, done_d, ovf_q, ovf_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    en_d   = en_q;
    ovf_d  = ovf_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SETTLE;
          tmr_d = TMR_W'(settle_len);
          sel_d = div_sel;
          cnt_d = '0;
          ovf_d = 1'b0;
          en_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_q == '0) begin
          st_d  = ST_COUNT;
          tmr_d = TMR_W'(window_len);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_COUNT: begin
        if (edge_pulse) begin
          if (cnt_q == CNT_MAX) ovf_d = 1'b1;
          else                  cnt_d = cnt_q + 1'b1;
        end
        if (tmr_q <= TMR_W'(1)) begin
          st_d   = ST_DONE;
          en_d   = 1'b0;
          done_d = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      en_q   <= en_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign osc_en   = en_q;
  assign done     = done_q;
  assign overflow = ovf_q;
  assign busy     = (st_q != ST_IDLE);
  assign result   = RES_W'(cnt_q) << sel_q;
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter #(
  parameter int CNT_W  = 12,
  parameter int WIN_W  = 16,
  parameter int SET_W  = 8,
  parameter int STAGES = 7,
  localparam int SEL_W = $clog2(STAGES + 1),
  localparam int RES_W = CNT_W + STAGES
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             osc_clk,
  input  logic             start,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [SET_W-1:0] settle_len,
  input  logic [WIN_W-1:0] window_len,
  output logic             osc_en,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             overflow
);
  logic             rst_n_ref;
  logic             tap;
  logic             tap_rise;
  logic [SEL_W-1:0] sel_q;

  ofm_rst_sync u_rst_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_ref)
  );

  ofm_divider #(.STAGES(STAGES)) u_div (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .sel     (sel_q),
    .tap_out (tap)
  );

  ofm_edge_sync u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n_ref),
    .async_in (tap),
    .rise     (tap_rise)
  );

  ofm_ctrl #(
    .CNT_W (CNT_W), .WIN_W (WIN_W), .SET_W (SET_W), .STAGES(STAGES)
  ) u_ctrl (
    .clk        (clk_ref),
    .rst_n      (rst_n_ref),
    .start      (start),
    .div_sel    (div_sel),
    .settle_len (settle_len),
    .window_len (window_len),
    .edge_pulse (tap_rise),
    .osc_en     (osc_en),
    .busy       (busy),
    .done       (done),
    .overflow   (overflow),
    .sel_q      (sel_q),
    .result     (result)
  );
endmodule

// File: rtl/ofm_checker.sv
module ofm_checker #(
  parameter int CNT_W = 12,
  parameter int SEL_W = 3,
  parameter int RES_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             osc_en,
  input logic             overflow,
  input logic [SEL_W-1:0] sel_q,
  input logic [RES_W-1:0] result
);
  assert_idle_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !osc_en);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_gate_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(osc_en));

  assert_idle_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_low_bits_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result & ~({RES_W{1'b1}} << sel_q)) == '0));

  assert_sat_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> ((result >> sel_q) == RES_W'({CNT_W{1'b1}})));

  assert_sel_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(sel_q)));
endmodule

bind osc_freq_meter ofm_checker #(
  .CNT_W (CNT_W), .SEL_W (SEL_W), .RES_W (RES_W)
) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .osc_en   (osc_en),
  .overflow (overflow),
  .sel_q    (sel_q),
  .result   (result)
);

// File: tb/osc_freq_meter_bench.sv
`timescale 1ns/1ps
module osc_freq_meter_bench;
  logic        clk_ref = 1'b0;
  logic        rst_n   = 1'b0;
  logic        osc_clk = 1'b0;
  logic        start   = 1'b0;
  logic [2:0]  div_sel = '0;
  logic [7:0]  settle_len = '0;
  logic [15:0] window_len = '0;
  logic        osc_en, busy, done, overflow;
  logic [18:0] result;

  int  n_checks = 0;
  int  n_fails  = 0;
  real osc_half = 3.0;

  osc_freq_meter u_osc_freq_meter (
    .clk_ref, .rst_n, .osc_clk, .start, .div_sel, .settle_len,
    .window_len, .osc_en, .busy, .done, .result, .overflow
  );

  always #10 clk_ref = ~clk_ref;

  // oscillator model: runs only while gated on, rests low otherwise
  always begin
    #(osc_half);
    if (osc_en) osc_clk = ~osc_clk;
    else        osc_clk = 1'b0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  // launch one measurement, return done latency in edges after acceptance
  task automatic run_meas(input int n, input int s, input int w, input bit disturb,
                          output int lat);
    @(negedge clk_ref);
    div_sel = 3'(n); settle_len = 8'(s); window_len = 16'(w); start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    check(busy && osc_en, "R2 busy/osc_en after start", {busy, osc_en}, 3);
    lat = 0;
    while (!done && lat < 20000) begin
      if (disturb && lat == 20) begin div_sel = 3'd0; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk_ref);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check(!osc_en && !busy && !done && !overflow, "R1 control outputs in reset",
          {osc_en, busy, done, overflow}, 0);
    check(result == 0, "R1 result in reset", result, 0);
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);
    check(!osc_en && !busy && !done && !overflow && result == 0,
          "R1 outputs after release", {osc_en, busy, done, overflow}, 0);
    check(!osc_en, "R2 gate closed while idle", osc_en, 0);
  endtask

  task automatic t_measure(input string tag, input int n, input real half,
                           input int s, input int w, input bit disturb);
    int  lat, eff_w;
    real exp_edges, got;
    osc_half = half;
    eff_w = (w < 1) ? 1 : w;
    run_meas(n, s, w, disturb, lat);
    check(lat == s + eff_w + 1, {tag, " R3 done latency"}, lat, s + eff_w + 1);
    check(!osc_en, {tag, " R3 gate closed at done"}, osc_en, 0);
    check((result & ((19'd1 << n) - 1)) == 0, {tag, " R6 low bits clear"}, result, 0);
    exp_edges = real'(eff_w) * 20.0 / (2.0 * half * real'(1 << n));
    got = real'(result >> n);
    check((got - exp_edges) <= 1.5 && (exp_edges - got) <= 1.5,
          {tag, " R4 R5 edge count"}, longint'(got), longint'(exp_edges));
    check(!overflow, {tag, " R7 no overflow"}, overflow, 0);
    @(negedge clk_ref);
    check(!done && !busy, {tag, " R3 single done pulse, idle after"}, {done, busy}, 0);
    check(result == (19'(longint'(got)) << n), {tag, " R6 result held"}, result,
          longint'(got) << n);
  endtask

  task automatic t_overflow();
    int lat;
    osc_half = 3.0;
    run_meas(3, 2, 12000, 1'b0, lat);
    check(lat == 12003, "R3 long window latency", lat, 12003);
    check(overflow, "R7 overflow set", overflow, 1);
    check(result == (19'd4095 << 3), "R7 saturated result", result, 4095 << 3);
    @(negedge clk_ref);
    check(overflow, "R7 overflow held while idle", overflow, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_measure("mid", 3, 3.0, 5, 200, 1'b0);
    t_measure("r64", 6, 1.0, 10, 640, 1'b0);
    t_measure("raw", 0, 50.0, 0, 100, 1'b0);
    t_measure("r128", 7, 1.0, 2, 1000, 1'b0);
    t_measure("zero_win", 3, 3.0, 3, 0, 1'b0);
    t_overflow();
    t_measure("after_ovf R7", 3, 3.0, 1, 150, 1'b0);
    t_measure("disturb R8", 3, 3.0, 4, 300, 1'b1);
    finish_run();
  end
endmodule